// File: doc/BRIEF.md
# Ethernet Pause Mode Resolver

This block settles, once a link has come up, whether the MAC should send pause frames, honour received pause frames, both, or neither. On a single-cycle `resolve` strobe it samples the local and partner advertisement bits (symmetric pause and asymmetric direction), the mode the user asked for, a strict-standard flag, the negotiated duplex and an autonegotiation-failed flag. It registers a 2-bit resolved mode together with separate transmit and receive pause enables.

In the same update it produces the two receive-FIFO threshold values for the flow-control logic. The low threshold can carry an XON-enable flag. Both thresholds are zero whenever transmit pause is off. A requested-mode code outside the legal set raises a configuration-error flag and leaves every other output at its earlier value.

All pins are plain control and status signals. The block has no streaming data path, so there is no valid/ready handshake and no back-pressure: each strobe produces exactly one registered update, and `done` pulses with it.

Top module: `pause_resolver`

## Requirements
- R1: While `rst_n` is low, and after reset until the first strobe, `mode`, `tx_pause_en`, `rx_pause_en`, `thresh_lo`, `thresh_hi`, `cfg_err` and `done` are all zero.
- R2: The outputs change only on a rising edge where `resolve` is high. `done` is high for exactly the cycle after each such edge and low otherwise.
- R3: The `req_mode` codes are: 0 none, 1 receive-only, 2 transmit-only, 3 full, 4 default. Default behaves as full. When autonegotiation succeeded and both local and partner pause bits are 1, the result is full (3) for a full or default request and receive-only (1) for any other legal request.
- R4: With autonegotiation ok, local pause=0 and asym=1, and partner pause=1 and asym=1, the result is transmit-only (2).
- R5: With autonegotiation ok, local pause=1 and asym=1, and partner pause=0 and asym=1, the result is receive-only (1).
- R6: With autonegotiation ok and any other advertisement combination, the result is none (0) when the request is none or transmit-only or `strict_std` is high. Otherwise it is receive-only (1).
- R7: With autonegotiation ok, `full_duplex` low forces the result to none (0), whatever the advertisements.
- R8: With `an_failed` high, the result equals the request (default gives full), and advertisements and duplex are ignored.
- R9: Mode encoding: 0 none, 1 receive-only, 2 transmit-only, 3 full. `rx_pause_en` is mode bit 0 and `tx_pause_en` is mode bit 1.
- R10: A strobe with `req_mode` 5, 6 or 7 sets `cfg_err` and keeps `mode`, the enables and the thresholds unchanged. The next strobe with a legal request clears `cfg_err`.
- R11: When the new result enables transmit pause, `thresh_hi` = `high_water` and `thresh_lo` = `low_water`, with bit 31 (the XON flag) set exactly when `send_xon` is high. When transmit pause is disabled, both thresholds are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resolve | input | 1 | One-cycle strobe starting a resolution |
| loc_pause | input | 1 | Local symmetric pause advertised |
| loc_asym | input | 1 | Local asymmetric direction advertised |
| lp_pause | input | 1 | Partner symmetric pause advertised |
| lp_asym | input | 1 | Partner asymmetric direction advertised |
| req_mode | input | 3 | Requested mode code (see R3) |
| strict_std | input | 1 | Disable the legacy receive-only fallback |
| full_duplex | input | 1 | Negotiated duplex is full |
| an_failed | input | 1 | Autonegotiation failed; apply request directly |
| send_xon | input | 1 | Request XON flag in low threshold |
| low_water | input | 16 | Low watermark value |
| high_water | input | 16 | High watermark value |
| mode | output | 2 | Resolved mode code |
| tx_pause_en | output | 1 | Transmit pause enable |
| rx_pause_en | output | 1 | Receive pause enable |
| thresh_lo | output | 32 | Low threshold value with XON flag |
| thresh_hi | output | 32 | High threshold value |
| cfg_err | output | 1 | Last strobe carried an illegal request |
| done | output | 1 | Pulses one cycle after a strobe |

## Verification
The assertions assume that inputs matter only in the cycle `resolve` is high. They also assume that a strobe is a single-cycle pulse, so each strobe yields one update and one `done`. The half-duplex and illegal-request properties sample the inputs at that same edge. The bench therefore changes every input at falling edges only, holds `resolve` for exactly one cycle per case, and lowers it again before it samples the outputs. This keeps each resolution distinct and the previous result visible for the hold checks.

// File: rtl/pause_res_pkg.sv
package pause_res_pkg;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_RX   = 2'd1,
    PM_TX   = 2'd2,
    PM_FULL = 2'd3
  } pmode_e;

  localparam int REQ_W = 3;

  localparam logic [REQ_W-1:0] RQ_NONE    = 3'd0;
  localparam logic [REQ_W-1:0] RQ_RX      = 3'd1;
  localparam logic [REQ_W-1:0] RQ_TX      = 3'd2;
  localparam logic [REQ_W-1:0] RQ_FULL    = 3'd3;
  localparam logic [REQ_W-1:0] RQ_DEFAULT = 3'd4;

  typedef struct packed {
    logic pause;
    logic asym;
  } adv_t;

endpackage

// File: rtl/pr_request_norm.sv
module pr_request_norm
  import pause_res_pkg::*;
(
  input  logic [REQ_W-1:0] req_code,
  output logic             req_ok,
  output pmode_e           req_eff
);
  // Default maps to full; codes above default are illegal.
  always_comb begin
    req_ok  = 1'b1;
    req_eff = PM_NONE;
    unique case (req_code)
      RQ_NONE:    req_eff = PM_NONE;
      RQ_RX:      req_eff = PM_RX;
      RQ_TX:      req_eff = PM_TX;
      RQ_FULL:    req_eff = PM_FULL;
      RQ_DEFAULT: req_eff = PM_FULL;
      default:    req_ok  = 1'b0;
    endcase
  end
endmodule

// File: rtl/pr_negotiate.sv
module pr_negotiate
  import pause_res_pkg::*;
(
  input  adv_t   local_adv,
  input  adv_t   peer_adv,
  input  pmode_e want,
  input  logic   strict_std,
  input  logic   full_duplex,
  output pmode_e result
);
  pmode_e table_mode;

  always_comb begin
    if (local_adv.pause && peer_adv.pause) begin
      table_mode = (want == PM_FULL) ? PM_FULL : PM_RX;
    end else if (!local_adv.pause && local_adv.asym && peer_adv.pause && peer_adv.asym) begin
      table_mode = PM_TX;
    end else if (local_adv.pause && local_adv.asym && !peer_adv.pause && peer_adv.asym) begin
      table_mode = PM_RX;
    end else if (want == PM_NONE || want == PM_TX || strict_std) begin
      table_mode = PM_NONE;
    end else begin
      // legacy partner that advertises nothing: still honour incoming pause
      table_mode = PM_RX;
    end
    result = full_duplex ? table_mode : PM_NONE;
  end
endmodule

// File: rtl/pr_thresh.sv
module pr_thresh #(
  parameter int WM_W     = 16,
  parameter int THRESH_W = 32,
  parameter int XON_BIT  = THRESH_W - 1
) (
  input  logic                tx_active,
  input  logic                xon_req,
  input  logic [WM_W-1:0]     low_wm,
  input  logic [WM_W-1:0]     high_wm,
  output logic [THRESH_W-1:0] lo_val,
  output logic [THRESH_W-1:0] hi_val
);
  localparam int PAD_W = THRESH_W - WM_W;

  logic [THRESH_W-1:0] lo_ext;
  logic [THRESH_W-1:0] hi_ext;
  logic [THRESH_W-1:0] xon_mask;

  generate
    if (PAD_W > 0) begin : g_pad
      assign lo_ext = {{PAD_W{1'b0}}, low_wm};
      assign hi_ext = {{PAD_W{1'b0}}, high_wm};
    end else begin : g_nopad
      assign lo_ext = low_wm[THRESH_W-1:0];
      assign hi_ext = high_wm[THRESH_W-1:0];
    end
  endgenerate

  always_comb begin
    xon_mask          = '0;
    xon_mask[XON_BIT] = xon_req;
    lo_val = tx_active ? (lo_ext | xon_mask) : '0;
    hi_val = tx_active ? hi_ext : '0;
  end
endmodule

// File: rtl/pause_resolver.sv
module pause_resolver
  import pause_res_pkg::*;
#(
  parameter int WM_W     = 16,
  parameter int THRESH_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                resolve,
  input  logic                loc_pause,
  input  logic                loc_asym,
  input  logic                lp_pause,
  input  logic                lp_asym,
  input  logic [2:0]          req_mode,
  input  logic                strict_std,
  input  logic                full_duplex,
  input  logic                an_failed,
  input  logic                send_xon,
  input  logic [WM_W-1:0]     low_water,
  input  logic [WM_W-1:0]     high_water,
  output logic [1:0]          mode,
  output logic                tx_pause_en,
  output logic                rx_pause_en,
  output logic [THRESH_W-1:0] thresh_lo,
  output logic [THRESH_W-1:0] thresh_hi,
  output logic                cfg_err,
  output logic                done
);
  logic   req_ok;
  pmode_e req_eff;
  pmode_e neg_mode;
  pmode_e next_mode;
  adv_t   loc_adv;
  adv_t   peer_adv;
  logic [THRESH_W-1:0] lo_nx;
  logic [THRESH_W-1:0] hi_nx;

  pmode_e              mode_q;
  logic                tx_q, rx_q, err_q, done_q;
  logic [THRESH_W-1:0] lo_q, hi_q;

  assign loc_adv  = '{pause: loc_pause, asym: loc_asym};
  assign peer_adv = '{pause: lp_pause,  asym: lp_asym};

  pr_request_norm u_norm (
    .req_code (req_mode),
    .req_ok   (req_ok),
    .req_eff  (req_eff)
  );

  pr_negotiate u_neg (
    .local_adv   (loc_adv),
    .peer_adv    (peer_adv),
    .want        (req_eff),
    .strict_std  (strict_std),
    .full_duplex (full_duplex),
    .result      (neg_mode)
  );

  // forced path bypasses advertisement table and duplex override
  assign next_mode = an_failed ? req_eff : neg_mode;

  pr_thresh #(
    .WM_W     (WM_W),
    .THRESH_W (THRESH_W)
  ) u_thr (
    .tx_active (next_mode[1]),
    .xon_req   (send_xon),
    .low_wm    (low_water),
    .high_wm   (high_water),
    .lo_val    (lo_nx),
    .hi_val    (hi_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PM_NONE;
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      lo_q   <= '0;
      hi_q   <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= resolve;
      if (resolve) begin
        err_q <= !req_ok;
        if (req_ok) begin
          mode_q <= next_mode;
          tx_q   <= (next_mode == PM_TX) || (next_mode == PM_FULL);
          rx_q   <= (next_mode == PM_RX) || (next_mode == PM_FULL);
          lo_q   <= lo_nx;
          hi_q   <= hi_nx;
        end
      end
    end
  end

  assign mode        = mode_q;
  assign tx_pause_en = tx_q;
  assign rx_pause_en = rx_q;
  assign thresh_lo   = lo_q;
  assign thresh_hi   = hi_q;
  assign cfg_err     = err_q;
  assign done        = done_q;
endmodule

// File: rtl/pause_resolver_chk.sv
module pause_resolver_chk #(
  parameter int THRESH_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                resolve,
  input logic [2:0]          req_mode,
  input logic                full_duplex,
  input logic                an_failed,
  input logic [1:0]          mode,
  input logic                tx_pause_en,
  input logic                rx_pause_en,
  input logic [THRESH_W-1:0] thresh_lo,
  input logic [THRESH_W-1:0] thresh_hi,
  input logic                cfg_err,
  input logic                done
);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |=> done);

  assert_no_stray_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> !done);

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> ($stable(mode) && $stable(tx_pause_en) && $stable(rx_pause_en)
                  && $stable(thresh_lo) && $stable(thresh_hi) && $stable(cfg_err)));

  assert_halfdup_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && !an_failed && !full_duplex && req_mode <= 3'd4) |=> (mode == 2'd0));

  assert_enable_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pause_en == mode[1]) && (rx_pause_en == mode[0]));

  assert_bad_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve && req_mode > 3'd4) |=> (cfg_err && $stable(mode) && $stable(thresh_lo)));

  assert_thresh_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_pause_en |-> (thresh_lo == '0 && thresh_hi == '0));
endmodule

bind pause_resolver pause_resolver_chk #(.THRESH_W(THRESH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .resolve     (resolve),
  .req_mode    (req_mode),
  .full_duplex (full_duplex),
  .an_failed   (an_failed),
  .mode        (mode),
  .tx_pause_en (tx_pause_en),
  .rx_pause_en (rx_pause_en),
  .thresh_lo   (thresh_lo),
  .thresh_hi   (thresh_hi),
  .cfg_err     (cfg_err),
  .done        (done)
);

// File: tb/pause_resolver_tb_top.sv
`timescale 1ns/1ps
module pause_resolver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        resolve;
  logic        loc_pause, loc_asym, lp_pause, lp_asym;
  logic [2:0]  req_mode;
  logic        strict_std, full_duplex, an_failed, send_xon;
  logic [15:0] low_water, high_water;
  logic [1:0]  mode;
  logic        tx_pause_en, rx_pause_en, cfg_err, done;
  logic [31:0] thresh_lo, thresh_hi;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pause_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .resolve(resolve),
    .loc_pause(loc_pause), .loc_asym(loc_asym), .lp_pause(lp_pause), .lp_asym(lp_asym),
    .req_mode(req_mode), .strict_std(strict_std), .full_duplex(full_duplex),
    .an_failed(an_failed), .send_xon(send_xon),
    .low_water(low_water), .high_water(high_water),
    .mode(mode), .tx_pause_en(tx_pause_en), .rx_pause_en(rx_pause_en),
    .thresh_lo(thresh_lo), .thresh_hi(thresh_hi), .cfg_err(cfg_err), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected resolved mode from the requirement text; -1 for illegal request
  function automatic int model(input int lpz, input int las, input int ppz, input int pas,
                               input int rq, input int st, input int fd, input int anf,
                               output string tag);
    int eff, m;
    if (rq > 4) begin tag = "R10"; return -1; end
    eff = (rq == 4) ? 3 : rq;
    if (anf != 0) begin tag = "R8"; return eff; end
    if (lpz != 0 && ppz != 0) begin
      m = (eff == 3) ? 3 : 1; tag = "R3";
    end else if (lpz == 0 && las != 0 && ppz != 0 && pas != 0) begin
      m = 2; tag = "R4";
    end else if (lpz != 0 && las != 0 && ppz == 0 && pas != 0) begin
      m = 1; tag = "R5";
    end else begin
      m = (eff == 0 || eff == 2 || st != 0) ? 0 : 1; tag = "R6";
    end
    if (fd == 0) begin m = 0; tag = "R7"; end
    return m;
  endfunction

  initial begin
    #900000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int exp_m, exp_lo, exp_hi;
    string tag;
    rst_n = 1'b0; resolve = 1'b0;
    loc_pause = 0; loc_asym = 0; lp_pause = 0; lp_asym = 0;
    req_mode = 0; strict_std = 0; full_duplex = 1; an_failed = 0; send_xon = 0;
    low_water = 16'h1234; high_water = 16'h5678;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mode == 0 && !tx_pause_en && !rx_pause_en && !cfg_err && !done,
        "R1", "reset flags", {mode, tx_pause_en, rx_pause_en, cfg_err, done}, 0);
    chk(thresh_lo == 0 && thresh_hi == 0, "R1", "reset thresholds",
        {thresh_lo, thresh_hi}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode == 0 && !done && thresh_lo == 0, "R1", "after reset",
        {mode, done}, 0);

    exp_m = 0; exp_lo = 0; exp_hi = 0;
    for (int adv = 0; adv < 16; adv++) begin
      for (int rq = 0; rq < 8; rq++) begin
        for (int f = 0; f < 16; f++) begin
          int m;
          {loc_pause, loc_asym, lp_pause, lp_asym} = 4'(adv);
          req_mode    = 3'(rq);
          strict_std  = f[0];
          full_duplex = f[1];
          an_failed   = f[2];
          send_xon    = f[3];
          low_water   = 16'(adv * 257 + rq * 31 + f * 7 + 5);
          high_water  = low_water ^ 16'hA5C3;
          resolve     = 1'b1;
          @(negedge clk);
          resolve     = 1'b0;
          m = model(adv >> 3 & 1, adv >> 2 & 1, adv >> 1 & 1, adv & 1,
                    rq, f & 1, f >> 1 & 1, f >> 2 & 1, tag);
          chk(done == 1'b1, "R2", "done after strobe", done, 1);
          if (m < 0) begin
            chk(cfg_err == 1'b1, "R10", "cfg_err set", cfg_err, 1);
            chk(mode == 2'(exp_m), "R10", "mode held", mode, exp_m);
            chk(thresh_lo == 32'(exp_lo) && thresh_hi == 32'(exp_hi), "R10",
                "thresholds held", thresh_lo, exp_lo);
          end else begin
            exp_m = m;
            if (m >= 2) begin
              exp_lo = int'(low_water) | (f[3] ? 32'h8000_0000 : 0);
              exp_hi = int'(high_water);
            end else begin
              exp_lo = 0; exp_hi = 0;
            end
            chk(cfg_err == 1'b0, "R10", "cfg_err clear", cfg_err, 0);
            chk(mode == 2'(m), tag, "resolved mode", mode, m);
            chk(tx_pause_en == (m >= 2) && rx_pause_en == (m == 1 || m == 3),
                "R9", "enables", {tx_pause_en, rx_pause_en}, {m >= 2, m == 1 || m == 3});
            chk(thresh_lo == 32'(exp_lo), "R11", "low threshold", thresh_lo, exp_lo);
            chk(thresh_hi == 32'(exp_hi), "R11", "high threshold", thresh_hi, exp_hi);
          end
        end
      end
    end

    // R2: idle inputs change, nothing moves and done stays low
    @(negedge clk);
    chk(done == 1'b0, "R2", "done drops", done, 0);
    loc_pause = ~loc_pause; req_mode = 3'd3; full_duplex = ~full_duplex;
    low_water = 16'hFFFF; high_water = 16'hFFFF; an_failed = 1'b1;
    repeat (3) @(negedge clk);
    chk(mode == 2'(exp_m) && !done, "R2", "hold without strobe", mode, exp_m);
    chk(thresh_lo == 32'(exp_lo) && thresh_hi == 32'(exp_hi), "R2",
        "thresholds hold without strobe", thresh_hi, exp_hi);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule